// File: doc/BRIEF.md
# Streaming Integer Multiplier with Registered Operands

This block multiplies two unsigned integers that arrive packed in one message on a valid/ready input stream. It returns the low half of the product on a valid/ready output stream. The two operands are written into a pair of operand registers along with an occupancy flag. The product is then computed combinationally from those registers. The block holds at most one transaction. When the consumer withholds ready, the held operands and the result stay frozen until the result is taken.

A message moves across either interface only on a clock edge where valid and ready are both high. A message that is not taken stays on offer. The output valid comes only from the occupancy flag and never from any ready signal. Consumers therefore work the same whatever the latency of the multiplier behind the stream. Input ready is a function of the output ready and the occupancy flag only, and never of the input valid. With an always-ready consumer, a result appears one cycle after its operands are accepted, and a new operand pair can be accepted on every cycle.

Top module: `strm_mul`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears the occupancy flag and both operand registers. After that edge `out_valid` is 0, `in_ready` is 1 and `out_data` is 0, including when a result was being held.
- R2: `out_data` equals the low OPW bits of the unsigned product of `in_data[2*OPW-1:OPW]` (first factor) and `in_data[OPW-1:0]` (second factor), taken from the accepted message.
- R3: When operands are accepted at a clock edge, `out_valid` is 1 in the cycle that follows, carrying their product.
- R4: Every accepted operand pair produces exactly one result transfer, and results leave in the order of acceptance. Nothing is transferred unless valid and ready are both high at the edge.
- R5: While `out_valid` is 1 and `out_ready` is 0, the next cycle still shows `out_valid` = 1 with an unchanged `out_data`.
- R6: `in_ready` equals 1 exactly when `out_valid` is 0 or `out_ready` is 1. The value of `in_valid` has no effect on it.
- R7: With `out_ready` held at 1, a new operand pair is accepted on every cycle, without gaps.
- R8: When a result is taken and no new operands are accepted at the same edge, `out_valid` is 0 in the next cycle.
- R9: An operand pair offered while `in_ready` is 0 is ignored. The held result on `out_data` is unchanged until the stall ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Producer offers an operand pair |
| in_ready | output | 1 | Block can take an operand pair this cycle |
| in_data | input | 2*OPW | First factor in the upper half, second factor in the lower half |
| out_valid | output | 1 | A result is on offer |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | OPW | Low OPW bits of the product |

## Verification
Some behaviours are checked by assertions on every cycle: the reset state, the one-cycle appearance of a result after acceptance, and the frozen output during a stall. The assertions also check that a result holds the product of the message accepted on the previous edge, the relation between the two ready signals, and the drop of the output valid after a drain. Other behaviours need the bench's scenarios. These are the ordering and completeness of results under random back-pressure, full throughput in a burst, rejection of operands offered during a stall, and reset while a result is held. The arithmetic corner cases are covered in the bench as well: all-ones operands, overflow wrapping to zero, and zero factors.

// File: rtl/strm_mul_pkg.sv
// Package: shared settings for the streaming multiplier.
// Assumes nothing beyond IEEE 1800-2017 packages.
package strm_mul_pkg;

    // Default operand width in bits.
    localparam int unsigned DEF_OPW = 32;

    // Structure used to form the product.
    typedef enum logic {
        MUL_INFER    = 1'b0,   // single multiply operator
        MUL_SHIFTADD = 1'b1    // explicit chain of conditional adds
    } mul_arch_e;

endpackage

// File: rtl/strm_mul_hs.sv
// Module: handshake control for a one-entry stage.
// Tracks whether the operand registers hold an unconsumed transaction.
// Assumes the consumer samples out_valid && out_ready at the clock edge.
// in_ready depends only on out_ready and the occupancy flag.
module strm_mul_hs (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic full,
    output logic in_ready,
    output logic load
);

    // Room exists if empty, or if the held result leaves this cycle.
    always_comb begin
        in_ready = !full || out_ready;
        load     = in_valid && in_ready;
    end

    // Occupancy flag: set on accept, cleared on drain, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
        end else if (load) begin
            full <= 1'b1;
        end else if (out_ready) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/strm_mul_opnd.sv
// Module: operand register pair.
// Splits the packed message and stores both factors when load is high.
// Assumes load is asserted only on an accepted input transfer.
module strm_mul_opnd #(
    parameter int unsigned OPW = 32,
    localparam int unsigned MW = 2 * OPW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [MW-1:0]  msg,
    output logic [OPW-1:0] opa,
    output logic [OPW-1:0] opb
);

    // Operand capture: upper half is the first factor, lower half the second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa <= '0;
            opb <= '0;
        end else if (load) begin
            opa <= msg[MW-1:OPW];
            opb <= msg[OPW-1:0];
        end
    end

endmodule

// File: rtl/strm_mul_core.sv
// Module: combinational unsigned multiplier, low half only.
// ARCH selects an inferred operator or an explicit conditional-add chain.
// Assumes the operands are stable for the whole cycle.
module strm_mul_core
    import strm_mul_pkg::*;
#(
    parameter int unsigned OPW  = 32,
    parameter mul_arch_e   ARCH = MUL_INFER
) (
    input  logic [OPW-1:0] a,
    input  logic [OPW-1:0] b,
    output logic [OPW-1:0] p
);

    generate
        if (ARCH == MUL_INFER) begin : g_infer
            // Product truncated to the operand width.
            always_comb p = a * b;
        end else begin : g_chain
            logic [OPW-1:0] acc [OPW+1];
            assign acc[0] = '0;
            for (genvar i = 0; i < OPW; i++) begin : g_step
                // Add the shifted first factor when bit i of the second is set.
                assign acc[i+1] = acc[i] + (b[i] ? (a << i) : '0);
            end
            assign p = acc[OPW];
        end
    endgenerate

endmodule

// File: rtl/strm_mul.sv
// Module: streaming registered-input multiplier (top).
// Accepts a packed operand pair on a valid/ready stream and offers the
// low half of the unsigned product on a second valid/ready stream.
// Holds one transaction; out_valid comes from state only.
module strm_mul
    import strm_mul_pkg::*;
#(
    parameter int unsigned OPW  = DEF_OPW,
    parameter mul_arch_e   ARCH = MUL_INFER,
    localparam int unsigned MW  = 2 * OPW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [MW-1:0]  in_data,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [OPW-1:0] out_data
);

    logic           load;
    logic [OPW-1:0] opa;
    logic [OPW-1:0] opb;

    // Handshake and occupancy.
    strm_mul_hs u_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .full      (out_valid),
        .in_ready  (in_ready),
        .load      (load)
    );

    // Operand storage.
    strm_mul_opnd #(.OPW(OPW)) u_opnd (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .msg   (in_data),
        .opa   (opa),
        .opb   (opb)
    );

    // Product from the stored operands.
    strm_mul_core #(.OPW(OPW), .ARCH(ARCH)) u_core (
        .a (opa),
        .b (opb),
        .p (out_data)
    );

endmodule

// File: rtl/strm_mul_chk.sv
// Module: protocol and function checker for strm_mul, attached by bind.
// Assumes it observes the top-level ports only.
module strm_mul_chk #(
    parameter int unsigned OPW = 32,
    localparam int unsigned MW = 2 * OPW
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           in_ready,
    input logic [MW-1:0]  in_data,
    input logic           out_valid,
    input logic           out_ready,
    input logic [OPW-1:0] out_data
);

    // Low half of the product of a packed message.
    function automatic logic [OPW-1:0] lo_mul(input logic [MW-1:0] m);
        logic [OPW-1:0] x;
        x = m[MW-1:OPW] * m[OPW-1:0];
        return x;
    endfunction

    p_rst_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && in_ready && out_data == '0))
        else $error("R1 state not cleared by reset");

    p_product_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_data == lo_mul($past(in_data))))
        else $error("R2 wrong product");

    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid)
        else $error("R3 result not offered one cycle after accept");

    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
        else $error("R5 result changed during stall");

    p_busy_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready)
        else $error("R6 ready high while stalled");

    p_idle_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready)
        else $error("R6 ready low while empty");

    p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !(in_valid && in_ready)) |=> !out_valid)
        else $error("R8 valid stayed high after drain");

endmodule

bind strm_mul strm_mul_chk #(.OPW(OPW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/test_strm_mul.sv
// Bench: scoreboard test for strm_mul. Time unit taken as 1 ns, so the
// 20-unit period gives a 50 MHz clock. Inputs change at the falling
// edge; everything is sampled 5 units later, well before the rising edge.
module test_strm_mul;

    localparam int unsigned OPW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [2*OPW-1:0] in_data = '0;
    logic            out_valid;
    logic            out_ready = 1'b1;
    logic [OPW-1:0]  out_data;

    int n_chk = 0;
    int n_bad = 0;
    int sink_mode = 0;      // 0 always ready, 1 never ready, 2 random
    int waits = 0;          // extra cycles spent waiting for in_ready
    logic [OPW-1:0] sb[$];

    always #10 clk = ~clk;

    strm_mul i_strm_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // Sink: drives out_ready at each falling edge.
    always @(negedge clk) begin
        case (sink_mode)
            0:       out_ready <= 1'b1;
            1:       out_ready <= 1'b0;
            default: out_ready <= (($urandom % 3) != 0);
        endcase
    end

    // Monitor: pops the scoreboard on every output transfer.
    always @(negedge clk) begin
        #5;
        if (rst_n) begin
            check(in_ready == (!out_valid || out_ready), "R6 ready rule",
                  64'(in_ready), 64'(!out_valid || out_ready));
            if (out_valid && out_ready) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R4 unexpected result", 64'(out_data), 64'(0));
                end else begin
                    logic [OPW-1:0] e;
                    e = sb.pop_front();
                    check(out_data == e, "R2 product", 64'(out_data), 64'(e));
                end
            end
        end
    end

    // Driver: offers one pair, waits for acceptance, records the expectation.
    task automatic send(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
        logic [OPW-1:0] e;
        e = a * b;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = {a, b};
        #5;
        while (!in_ready) begin
            waits++;
            @(negedge clk);
            #5;
        end
        sb.push_back(e);
    endtask

    task automatic idle;
        @(negedge clk);
        in_valid = 1'b0;
        #5;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 64'(0), 64'(1));
        report();
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        #5;
        check(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'(0));
        check(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'(1));
        check(out_data == '0, "R1 out_data", 64'(out_data), 64'(0));
        @(negedge clk);
        rst_n = 1'b1;

        // R3 latency, R8 drain
        send(32'd7, 32'd6);
        idle();
        check(out_valid == 1'b1, "R3 valid next cycle", 64'(out_valid), 64'(1));
        check(out_data == 32'd42, "R3 result next cycle", 64'(out_data), 64'd42);
        idle();
        check(out_valid == 1'b0, "R8 valid drops", 64'(out_valid), 64'(0));

        // R2 corners and R7 throughput in one burst
        waits = 0;
        send(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        send(32'h8000_0000, 32'd2);
        send(32'h0001_0000, 32'h0001_0000);
        send(32'd0, 32'hDEAD_BEEF);
        send(32'd12345, 32'd6789);
        for (int i = 0; i < 16; i++) send($urandom, $urandom);
        check(waits == 0, "R7 back-to-back accepts", 64'(waits), 64'(0));
        idle();
        idle();

        // R5, R9: stall holds result and rejects new operands
        sink_mode = 1;
        send(32'd1000, 32'd3);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_valid = (k % 2 == 0);
            in_data  = {32'd55, 32'd66};
            #5;
            check(in_ready == 1'b0, "R9 ready low in stall", 64'(in_ready), 64'(0));
            check(out_valid == 1'b1, "R5 valid held", 64'(out_valid), 64'(1));
            check(out_data == 32'd3000, "R9 result unchanged", 64'(out_data), 64'd3000);
        end
        sink_mode = 0;
        send(32'd55, 32'd66);
        idle();
        check(out_valid && out_data == 32'd3630, "R4 pair after stall",
              64'(out_data), 64'd3630);
        idle();

        // R4: random back-pressure and gaps, all results delivered in order
        sink_mode = 2;
        for (int i = 0; i < 300; i++) begin
            if (($urandom % 4) == 0) idle();
            send($urandom, $urandom);
        end
        idle();
        sink_mode = 0;
        repeat (4) idle();
        check(sb.size() == 0, "R4 all results delivered", 64'(sb.size()), 64'(0));

        // R1: reset while a result is held
        sink_mode = 1;
        send(32'd9, 32'd9);
        idle();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #5;
        check(out_valid == 1'b0, "R1 reset drops held result", 64'(out_valid), 64'(0));
        check(out_data == '0, "R1 reset clears operands", 64'(out_data), 64'(0));
        sb.delete();
        sink_mode = 0;
        @(negedge clk);
        rst_n = 1'b1;
        idle();
        report();
    end

endmodule